// File: doc/BRIEF.md
# Iterative 512-bit Wide-State Permutation Engine

This block applies one of two keyed-by-mode permutations to a 512-bit state made of 64 bytes, arranged as an 8x8 byte matrix. Each round adds a round-dependent constant, then substitutes every byte through the AES S-box, then rotates each row by a mode-dependent number of columns, and finally mixes every column by a fixed circulant matrix over GF(2^8). One complete round is computed per clock. The engine steps through all rounds by itself once a state has been accepted. A single datapath serves both variants: the mode changes only the constants and the row rotation amounts.

The input side is a valid/ready stream. A state is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` stays low for the whole permutation. The output side is a one-cycle `out_valid` pulse with no ready signal, so the consumer cannot apply back-pressure. The result remains on `out_data` until the next accepted state, so a consumer that needs time can read it later. Message padding, chaining values and I/O buffering belong to the surrounding hash core.

Top module: `grs_perm_engine`

## Requirements
- R1: State byte (row r, column c), with r and c in 0..7, occupies bits [511-8*(8*c+r) -: 8] of `in_data` and `out_data`. Bytes fill column by column from the most significant end. `in_mode` = 0 selects variant P and `in_mode` = 1 selects variant Q.
- R2: The permutation runs ROUNDS = 10 rounds, numbered 0 to 9. Each round applies, in this order: add constant, byte substitution, row rotation, column mixing.
- R3: For variant P, round i XORs ((c<<4) ^ i) into the row-0 byte of column c and leaves every other byte unchanged.
- R4: For variant Q, round i XORs 0xFF into rows 0 to 6 and XORs (((c<<4) ^ i) ^ 0xFF) into the row-7 byte of column c.
- R5: For variant P, row r is rotated left by r columns, so output byte (r,c) takes input byte (r,(c+r) mod 8).
- R6: For variant Q, rows 0 to 7 are rotated left by 1, 3, 5, 7, 0, 2, 4, 6 columns respectively.
- R7: Substitution uses the AES S-box on all 64 bytes. Mixing sets output byte (r,c) to the XOR over k of coef[(k-r) mod 8] times byte (k,c), with coef = 02,02,03,04,05,03,05,07, multiplied in GF(2^8) with polynomial 0x11B.
- R8: `in_ready` is high exactly when no permutation is running. A state and its mode are captured on an edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from the next cycle on.
- R9: `out_valid` is high for exactly one cycle, beginning ROUNDS clock edges after the accepting edge. `in_ready` is already high in that cycle.
- R10: While a permutation is running, `in_valid`, `in_data` and `in_mode` have no effect on the result or on its timing.
- R11: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R12: `out_data` holds the result unchanged after the `out_valid` pulse until the next state is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | Engine idle; an offered state is taken this cycle |
| in_data | input | 512 | Input state, byte layout per R1 |
| in_mode | input | 1 | Variant select, 0 = P, 1 = Q |
| out_valid | output | 1 | One-cycle pulse marking a finished result |
| out_data | output | 512 | Permuted state, held until the next accept |

## Verification
The hardest situation to create from the ports is a second offer that arrives while a permutation is in flight, carrying different data and the opposite mode. If that offer leaked into the state or the mode register, the result would be corrupted only on some patterns. To reach this case, the stimulus keeps `in_valid` high with complemented data and an inverted mode for several middle rounds. It then checks that the result still matches the model for the original input and arrives at the normal cycle. Separately, a sweep over sixteen structured and pseudo-random states in both modes compares every result against a full bench-side model. That model builds its S-box and its field multiplication by a different method from the design.

// File: rtl/grs_pkg.sv
package grs_pkg;

  localparam int NROW = 8;
  localparam int NCOL = 8;
  localparam int BYTES = NROW * NCOL;
  localparam int STATE_W = 8 * BYTES;
  localparam int COL_W = 8 * NROW;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_dbl(t);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq = x;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] mix_coef(input int idx);
    case (idx)
      0, 1: return 8'h02;
      2, 5: return 8'h03;
      3: return 8'h04;
      4: return 8'h05;
      6: return 8'h05;
      default: return 8'h07;
    endcase
  endfunction

  function automatic int q_rot(input int r);
    case (r)
      0: return 1;
      1: return 3;
      2: return 5;
      3: return 7;
      4: return 0;
      5: return 2;
      6: return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/grs_sbox.sv
module grs_sbox
  import grs_pkg::*;
(
  input  logic [7:0] x_i,
  output logic [7:0] y_o
);
  assign y_o = sub_byte(x_i);
endmodule

// File: rtl/grs_mixcol.sv
module grs_mixcol
  import grs_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  function automatic logic [7:0] mix_row(input logic [COL_W-1:0] v, input int r);
    logic [7:0] acc;
    acc = 8'h00;
    for (int k = 0; k < NROW; k++)
      acc = acc ^ gf_mul(mix_coef((k - r + NROW) % NROW), v[COL_W-1-8*k -: 8]);
    return acc;
  endfunction

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign col_o[COL_W-1-8*r -: 8] = mix_row(col_i, r);
  end
endmodule

// File: rtl/grs_round.sv
module grs_round
  import grs_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic [STATE_W-1:0] st_i,
  input  logic [RW-1:0]      rnd_i,
  input  logic               q_i,
  output logic [STATE_W-1:0] st_o
);
  logic [7:0]       ac [NROW][NCOL];
  logic [7:0]       sb [NROW][NCOL];
  logic [7:0]       sh [NROW][NCOL];
  logic [COL_W-1:0] mix_in  [NCOL];
  logic [COL_W-1:0] mix_out [NCOL];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      localparam int LSB = STATE_W - 8 - 8 * (NROW * c + r);
      logic [7:0] cst;
      assign cst = 8'(c << 4) ^ 8'(rnd_i);
      // add constant: P touches row 0 only, Q inverts all rows and keys row 7
      if (r == 0) begin : g_top
        assign ac[r][c] = st_i[LSB +: 8] ^ (q_i ? 8'hFF : cst);
      end else if (r == NROW - 1) begin : g_bot
        assign ac[r][c] = st_i[LSB +: 8] ^ (q_i ? ~cst : 8'h00);
      end else begin : g_mid
        assign ac[r][c] = st_i[LSB +: 8] ^ (q_i ? 8'hFF : 8'h00);
      end

      grs_sbox u_sbox (.x_i(ac[r][c]), .y_o(sb[r][c]));

      // row rotation is pure wiring per variant, one 2:1 select between them
      assign sh[r][c] = q_i ? sb[r][(c + q_rot(r)) % NCOL] : sb[r][(c + r) % NCOL];
      assign mix_in[c][COL_W-8-8*r +: 8] = sh[r][c];
      assign st_o[LSB +: 8] = mix_out[c][COL_W-8-8*r +: 8];
    end

    grs_mixcol u_mix (.col_i(mix_in[c]), .col_o(mix_out[c]));
  end
endmodule

// File: rtl/grs_perm_engine.sv
module grs_perm_engine
  import grs_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [STATE_W-1:0] in_data,
  input  logic               in_mode,
  output logic               out_valid,
  output logic [STATE_W-1:0] out_data
);
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] next_st;
  logic [RW-1:0]      rnd_q;
  logic               busy_q;
  logic               q_mode_q;
  logic               done_q;
  logic               accept;

  assign accept = in_valid && !busy_q;

  grs_round #(.RW(RW)) u_round (
    .st_i  (state_q),
    .rnd_i (rnd_q),
    .q_i   (q_mode_q),
    .st_o  (next_st)
  );

  // feedback select: external state on accept, previous round otherwise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      rnd_q    <= '0;
      busy_q   <= 1'b0;
      q_mode_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q  <= in_data;
        q_mode_q <= in_mode;
        rnd_q    <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        state_q <= next_st;
        if (rnd_q == LAST) begin
          rnd_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + 1'b1;
        end
      end
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = done_q;
  assign out_data  = state_q;
endmodule

// File: rtl/grs_perm_engine_chk.sv
module grs_perm_engine_chk #(
  parameter int ROUNDS = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_mode,
  input logic         out_valid,
  input logic [511:0] out_data
);
  logic [15:0] since_q;
  logic        active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q  <= '0;
      active_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      since_q  <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      since_q <= since_q + 16'd1;
      if (out_valid) active_q <= 1'b0;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (active_q && since_q == 16'(ROUNDS)));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !out_valid) |=> $stable(out_data));

  // R10
  idle_only_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !in_ready) |=> (in_ready == out_valid) || !in_ready);
endmodule

bind grs_perm_engine grs_perm_engine_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/grs_perm_engine_tb_top.sv
`timescale 1ns/1ps
module grs_perm_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [511:0] in_data;
  logic         in_mode;
  logic         out_valid;
  logic [511:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] sbt [256];

  always #4 clk = ~clk;

  grs_perm_engine #(.ROUNDS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] mulc(input logic [7:0] k, input logic [7:0] v);
    case (k)
      8'h02: return xt(v);
      8'h03: return xt(v) ^ v;
      8'h04: return xt(xt(v));
      8'h05: return xt(xt(v)) ^ v;
      default: return xt(xt(v)) ^ xt(v) ^ v;
    endcase
  endfunction

  // R1 byte layout, R2 step order, R3/R4 constants, R5/R6 rotations, R7 mixing
  function automatic logic [511:0] model_round(input logic [511:0] st, input int rnd, input logic q);
    logic [7:0] a [8][8];
    logic [7:0] s [8][8];
    logic [7:0] coef [8];
    int qs [8];
    logic [511:0] o;
    logic [7:0] b;
    logic [7:0] acc;
    coef = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};
    qs = '{1, 3, 5, 7, 0, 2, 4, 6};
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        b = st[511-8*(8*c+r) -: 8];
        if (!q) begin
          if (r == 0) b = b ^ 8'((c << 4) ^ rnd);
        end else begin
          if (r == 7) b = b ^ 8'((c << 4) ^ rnd) ^ 8'hFF;
          else b = b ^ 8'hFF;
        end
        a[r][c] = sbt[b];
      end
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        s[r][c] = a[r][(c + (q ? qs[r] : r)) % 8];
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) begin
        acc = 8'h00;
        for (int k = 0; k < 8; k++) acc = acc ^ mulc(coef[(k - r + 8) % 8], s[k][c]);
        o[511-8*(8*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [511:0] model_perm(input logic [511:0] st, input logic q);
    logic [511:0] v;
    v = st;
    for (int i = 0; i < 10; i++) v = model_round(v, i, q);
    return v;
  endfunction

  function automatic logic [511:0] pattern(input int i);
    logic [511:0] v;
    for (int k = 0; k < 64; k++) begin
      case (i)
        0: v[511-8*k -: 8] = 8'h00;
        1: v[511-8*k -: 8] = 8'hFF;
        2: v[511-8*k -: 8] = 8'(k);
        3: v[511-8*k -: 8] = (k == 0) ? 8'h80 : 8'h00;
        4: v[511-8*k -: 8] = (k == 63) ? 8'h01 : 8'h00;
        default: v[511-8*k -: 8] = 8'(i * 37 + k * 11 + k * k * 3 + (i ^ k));
      endcase
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [511:0] d, input logic m, input bit noise);
    logic [511:0] exp;
    int cyc;
    string tg;
    exp = model_perm(d, m);
    tg = m ? "R1 R2 R4 R6 R7" : "R1 R2 R3 R5 R7";
    if (noise) tg = {tg, " R10"};
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready when idle", 512'(in_ready), 512'(1));
    in_valid = 1'b1; in_data = d; in_mode = m;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; in_mode = 1'b0;
    chk(in_ready == 1'b0, "R8 busy after accept", 512'(in_ready), 512'(0));
    cyc = 0;
    while (!out_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (noise && cyc >= 1 && cyc <= 5) begin
        chk(in_ready == 1'b0, "R10 offer while busy", 512'(in_ready), 512'(0));
        in_valid = 1'b1; in_data = ~d; in_mode = ~m;
      end else begin
        in_valid = 1'b0; in_data = '0; in_mode = 1'b0;
      end
    end
    in_valid = 1'b0;
    chk(cyc == 10, {"R9 latency", noise ? " R10" : ""}, 512'(cyc), 512'(10));
    chk(out_data == exp, tg, out_data, exp);
    chk(in_ready == 1'b1, "R9 ready at done", 512'(in_ready), 512'(1));
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 single pulse", 512'(out_valid), 512'(0));
    repeat (2) @(negedge clk);
    chk(out_data == exp, "R12 result held", out_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sbt[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sbt[0] = 8'h63;

    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    chk(in_ready == 1'b1, "R11 reset ready", 512'(in_ready), 512'(1));
    chk(out_valid == 1'b0, "R11 reset valid", 512'(out_valid), 512'(0));
    chk(out_data == '0, "R11 reset data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 2; m++)
        run_one(pattern(i), m[0], 1'b0);
    for (int i = 5; i < 9; i++) begin
      run_one(pattern(i), 1'b0, 1'b1);
      run_one(pattern(i), 1'b1, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule